// File: doc/BRIEF.md
# Free-Running Timer with Byte-Latched Reads

This block is a 16-bit up-counter that runs freely and is read through an 8-bit register port. The count can be read through two views, a primary one and an alternate one. Both views make a two-byte read coherent: reading the high byte also captures the low byte. A later low-byte read returns the captured value even if the counter has moved on. After a wrap, an overflow flag is set. It feeds an interrupt request that is gated by an enable bit and a global mask input. Software clears the flag in two steps. A status read comes first, followed by an access to the primary view. The alternate view never clears the flag, so code that only samples the time can use it safely.

The counter advances on an internal tick enable, or on edges of an external pin. The pin passes through a synchroniser and has a selectable active edge. A halt input freezes the count in place. Writing to the primary view returns the count to its reset value FFFCh.

Top module: `frt16_bytelatch`

## Requirements
- R1: After reset the count is FFFCh, the overflow flag is 0, the control register reads 00h and the interrupt request is 0.
- R2: When the source field (control bits 2:1) is not 11b, the count rises by exactly one for each cycle with tick_i high, and the external pin has no effect.
- R3: When the source field is 11b, the count rises by exactly one for each synchronised active edge of the external pin. Control bit 3 selects the edge: 1 is rising and 0 is falling. tick_i has no effect in this mode.
- R4: While halt_i is high the count holds its value. Counting resumes from that held value.
- R5: A read of the high byte of either view (address 0 or 2) captures the current low byte. The next low-byte read (address 1 or 3) returns that captured byte. Further high-byte reads before that low read do not replace it.
- R6: A low-byte read with no capture pending returns the live low byte.
- R7: A wrap from FFFFh to 0000h sets the overflow flag. The flag appears at status bit 7.
- R8: The flag is cleared by a status read that sees it set, followed by a read or write of the primary view (address 0 or 1). Accesses to the alternate view (address 2 or 3) leave the flag set.
- R9: A wrap that occurs between the status read and the primary access cancels the pending clear, and the flag stays set.
- R10: A write to address 0 or 1 loads FFFCh into the count and serves as the primary-access step of the clear.
- R11: irq_o is high exactly when the flag is set, control bit 0 (enable) is 1 and gmask_i is 0. A flag that is set while the request is gated stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | 0/1 primary hi/lo, 2/3 alternate hi/lo, 4 status, 5 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| tick_i | input | 1 | Internal prescaled count enable |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| halt_i | input | 1 | Freezes the count while high |
| gmask_i | input | 1 | Global interrupt mask, 1 blocks the request |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions check four things on every cycle. The count only holds or steps by one, except when the primary view is written. A primary write lands on FFFCh. Halt freezes the count. The request never rises while it is masked or disabled. They also tie the flag to each wrap, and allow a flag clear only after a primary access.

Some behaviours depend on the order of accesses, so only the bench scenarios can show them. These are the captured low byte surviving repeated high reads, the alternate view not clearing the flag, a wrap cancelling an armed clear, and the selected external edge polarity.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT_HI = 3'd0,
        A_CNT_LO = 3'd1,
        A_ALT_HI = 3'd2,
        A_ALT_LO = 3'd3,
        A_STAT   = 3'd4,
        A_CTRL   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_TICK_A = 2'b00,
        SRC_TICK_B = 2'b01,
        SRC_TICK_C = 2'b10,
        SRC_EXT    = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic     ext_rise;
        clk_src_e src;
        logic     ovf_ie;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic rd_hi;
        logic rd_lo;
        logic rd_stat;
        logic prim_acc;
        logic prim_wr;
        logic ctrl_wr;
    } bus_dec_t;

    function automatic bus_dec_t decode_access(input logic sel,
                                               input logic wr,
                                               input logic [ADDR_W-1:0] addr);
        bus_dec_t d;
        logic rd;
        rd = sel && !wr;
        d.rd_hi    = rd && (addr == A_CNT_HI || addr == A_ALT_HI);
        d.rd_lo    = rd && (addr == A_CNT_LO || addr == A_ALT_LO);
        d.rd_stat  = rd && (addr == A_STAT);
        d.prim_acc = sel && (addr == A_CNT_HI || addr == A_CNT_LO);
        d.prim_wr  = sel && wr && (addr == A_CNT_HI || addr == A_CNT_LO);
        d.ctrl_wr  = sel && wr && (addr == A_CTRL);
        return d;
    endfunction

endpackage

// File: rtl/frt_edge_sync.sv
`timescale 1ns/1ps
module frt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] stage_q;
    logic                   prev_q;
    logic                   rise_w;
    logic                   fall_w;

    // first stage samples on the falling clock edge
    always_ff @(negedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= pin_i;
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stage_q[SYNC_STAGES-1];
    end

    assign rise_w = stage_q[SYNC_STAGES-1] & ~prev_q;
    assign fall_w = ~stage_q[SYNC_STAGES-1] & prev_q;
    assign edge_o = rise_sel_i ? rise_w : fall_w;
endmodule

// File: rtl/frt_counter.sv
`timescale 1ns/1ps
module frt_counter #(
    parameter int          CNT_W     = 16,
    parameter logic [CNT_W-1:0] RESET_VAL = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) count_q <= RESET_VAL;
        else if (inc_i)    count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;
    assign wrap_o  = inc_i && !load_i && (count_q == ALL_ONES);
endmodule

// File: rtl/frt_read_latch.sv
`timescale 1ns/1ps
module frt_read_latch #(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*BUS_W-1:0] count_i,
    input  logic               rd_hi_i,
    input  logic               rd_lo_i,
    output logic [BUS_W-1:0]   lo_view_o
);
    logic [BUS_W-1:0] lo_buf_q;
    logic             held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_buf_q <= '0;
            held_q   <= 1'b0;
        end else if (rd_lo_i) begin
            held_q   <= 1'b0;
        end else if (rd_hi_i && !held_q) begin
            lo_buf_q <= count_i[BUS_W-1:0];
            held_q   <= 1'b1;
        end
    end

    assign lo_view_o = held_q ? lo_buf_q : count_i[BUS_W-1:0];
endmodule

// File: rtl/frt_ovf_flag.sv
`timescale 1ns/1ps
module frt_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic wrap_i,
    input  logic stat_rd_i,
    input  logic prim_acc_i,
    input  logic ie_i,
    input  logic gmask_i,
    output logic tof_o,
    output logic irq_o
);
    logic tof_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tof_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (wrap_i) begin
            tof_q   <= 1'b1;
            armed_q <= 1'b0;
        end else if (armed_q && prim_acc_i) begin
            tof_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (stat_rd_i) begin
            armed_q <= tof_q;
        end
    end

    assign tof_o = tof_q;
    assign irq_o = tof_q && ie_i && !gmask_i;
endmodule

// File: rtl/frt16_bytelatch.sv
`timescale 1ns/1ps
module frt16_bytelatch
    import frt_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [2*BUS_W-1:0] RESET_VAL = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [2:0]       addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    input  logic             tick_i,
    input  logic             ext_clk_i,
    input  logic             halt_i,
    input  logic             gmask_i,
    output logic             irq_o
);
    localparam int CNT_W = 2 * BUS_W;

    bus_dec_t         dec;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] count_q;
    logic [BUS_W-1:0] lo_view;
    logic             ext_edge;
    logic             inc;
    logic             wrap;
    logic             tof;
    logic             prim_wr;
    logic             prim_acc;
    logic             unused_wdata_hi;

    assign dec      = decode_access(sel_i, wr_i, addr_i);
    assign prim_wr  = dec.prim_wr;
    assign prim_acc = dec.prim_acc;
    assign unused_wdata_hi = ^wdata_i[BUS_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst)              ctrl_q <= '0;
        else if (dec.ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end

    frt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (ext_clk_i),
        .rise_sel_i (ctrl_q.ext_rise),
        .edge_o     (ext_edge)
    );

    assign inc = !halt_i && ((ctrl_q.src == SRC_EXT) ? ext_edge : tick_i);

    frt_counter #(.CNT_W(CNT_W), .RESET_VAL(RESET_VAL)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (inc),
        .load_i  (prim_wr),
        .count_o (count_q),
        .wrap_o  (wrap)
    );

    frt_read_latch #(.BUS_W(BUS_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .count_i   (count_q),
        .rd_hi_i   (dec.rd_hi),
        .rd_lo_i   (dec.rd_lo),
        .lo_view_o (lo_view)
    );

    frt_ovf_flag u_ovf (
        .clk        (clk),
        .rst        (rst),
        .wrap_i     (wrap),
        .stat_rd_i  (dec.rd_stat),
        .prim_acc_i (prim_acc),
        .ie_i       (ctrl_q.ovf_ie),
        .gmask_i    (gmask_i),
        .tof_o      (tof),
        .irq_o      (irq_o)
    );

    always_comb begin
        case (addr_i)
            A_CNT_HI, A_ALT_HI: rdata_o = count_q[CNT_W-1:BUS_W];
            A_CNT_LO, A_ALT_LO: rdata_o = lo_view;
            A_STAT:             rdata_o = {tof, {(BUS_W-1){1'b0}}};
            A_CTRL:             rdata_o = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
            default:            rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/frt_checker.sv
`timescale 1ns/1ps
module frt_checker #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RESET_VAL = 16'hFFFC
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             tof,
    input logic             irq,
    input logic             ie,
    input logic             gmask,
    input logic             halt,
    input logic             prim_wr,
    input logic             prim_acc
);
    // R2 / R3: the count holds or steps by exactly one unless loaded
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(prim_wr)) |->
            (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(halt) && !$past(prim_wr)) |-> count == $past(count));

    assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(count) == {CNT_W{1'b1}} && count == '0) |-> tof);

    assert_clear_needs_primary_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(tof) |-> $past(prim_acc));

    assert_write_loads_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(prim_wr)) |-> count == RESET_VAL);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie && !gmask && tof));
endmodule

bind frt16_bytelatch frt_checker #(.CNT_W(2*BUS_W), .RESET_VAL(RESET_VAL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .count    (count_q),
    .tof      (tof),
    .irq      (irq_o),
    .ie       (ctrl_q.ovf_ie),
    .gmask    (gmask_i),
    .halt     (halt_i),
    .prim_wr  (prim_wr),
    .prim_acc (prim_acc)
);

// File: tb/test_frt16_bytelatch.sv
`timescale 1ns/1ps
module test_frt16_bytelatch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick = 1'b0;
    logic       pin = 1'b0;
    logic       halt = 1'b0;
    logic       gmask = 1'b0;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    frt16_bytelatch i_frt16_bytelatch (
        .clk(clk), .rst(rst), .sel_i(sel), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .ext_clk_i(pin),
        .halt_i(halt), .gmask_i(gmask), .irq_o(irq)
    );

    // monitor: pops an expected byte for every read cycle
    always begin
        @(negedge clk);
        #5;
        if (sel && !wr && !rst) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: got %02h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: got %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic wrr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(posedge clk);
        #5 pin = v;
        repeat (6) @(posedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        #5;
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, 8'hFF, "R1 hi");
        rd(3'd1, 8'hFC, "R1 lo");
        rd(3'd4, 8'h00, "R1 status");
        rd(3'd5, 8'h00, "R1 control");
        chk_irq(1'b0, "R1 irq");

        // R5 capture survives repeated high reads; R6 live low read
        ticks(1);
        rd(3'd0, 8'hFF, "R5 first hi");
        ticks(1);
        rd(3'd0, 8'hFF, "R5 second hi");
        rd(3'd1, 8'hFD, "R5 captured lo");
        rd(3'd1, 8'hFE, "R6 live lo");

        // R7 wrap, R8 alternate view keeps flag, primary clears
        ticks(2);
        rd(3'd4, 8'h80, "R7 flag set");
        rd(3'd2, 8'h00, "R5 alt hi");
        rd(3'd3, 8'h00, "R5 alt lo");
        rd(3'd4, 8'h80, "R8 alt no clear");
        rd(3'd1, 8'h00, "R8 primary lo");
        rd(3'd4, 8'h00, "R8 cleared");

        // R10 write loads reset value
        wrr(3'd0, 8'h12);
        rd(3'd3, 8'hFC, "R10 loaded");

        // R11 gating and pending request
        wrr(3'd5, 8'h01);
        gmask = 1'b1;
        ticks(4);
        chk_irq(1'b0, "R11 masked");
        gmask = 1'b0;
        chk_irq(1'b1, "R11 pending fires");
        wrr(3'd5, 8'h00);
        chk_irq(1'b0, "R11 disabled");
        wrr(3'd5, 8'h01);
        chk_irq(1'b1, "R11 reenabled");

        // R9 wrap between steps cancels the clear
        rd(3'd4, 8'h80, "R9 arm");
        ticks(65536);
        rd(3'd1, 8'h00, "R9 primary lo");
        rd(3'd4, 8'h80, "R9 still set");
        wrr(3'd1, 8'h00);
        rd(3'd4, 8'h00, "R10 write clears");
        chk_irq(1'b0, "R10 irq low");
        rd(3'd1, 8'hFC, "R10 count");

        // R4 halt
        halt = 1'b1;
        ticks(3);
        rd(3'd1, 8'hFC, "R4 frozen");
        halt = 1'b0;
        ticks(2);
        rd(3'd1, 8'hFE, "R4 resumed");

        // R2 pin ignored on internal source
        set_pin(1'b1);
        set_pin(1'b0);
        rd(3'd1, 8'hFE, "R2 pin ignored");

        // R3 external rising edges, tick ignored
        wrr(3'd5, 8'h0E);
        ticks(3);
        rd(3'd1, 8'hFE, "R3 tick ignored");
        set_pin(1'b1);
        rd(3'd1, 8'hFF, "R3 rising counts");
        set_pin(1'b0);
        rd(3'd1, 8'hFF, "R3 falling ignored");
        set_pin(1'b1);
        rd(3'd1, 8'h00, "R3 ext wrap");
        rd(3'd4, 8'h80, "R7 ext wrap flag");
        wrr(3'd5, 8'h06);
        set_pin(1'b0);
        rd(3'd1, 8'h01, "R3 falling counts");
        set_pin(1'b1);
        rd(3'd1, 8'h01, "R3 rising ignored");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule